// File: doc/BRIEF.md
# State-Access Permission Checker

This block judges whether an instruction that touches state belonging to an optional extension may go ahead. If it may not, the block says which exception the trap logic must raise: an illegal-instruction exception or a virtual-instruction exception. It reads three banks of enable registers:

- the machine-level bank, which governs every mode below machine mode;
- the hypervisor-level bank, which governs only the guest modes;
- the supervisor-level bank, which governs only the user modes.

Each bank only restricts modes that are less privileged than its owner. The checks run from the most privileged bank down. A denial from the hypervisor bank becomes a virtual-instruction exception. Every other denial becomes an illegal-instruction exception.

The request names one enable bit with an 8-bit selector: the top two bits pick the register, the low six bits pick the bit. The same selector also serves requests that access the supervisor-level or hypervisor-level enable registers themselves. Those requests are gated by bit 63 of the selected register.

Floating-point instructions on a core without floating-point registers are covered as well. They are gated by register 0 bit 1, whatever the selector says.

The caller supplies the supervisor-level bank that is in effect for the current mode. That is the guest copy when a guest is running. The verdict is registered and appears one clock after the request. Instruction decoding and trap delivery stay outside.

Top module: `stateen_access_check`

## Requirements
- R1: Exactly one of allow_o, illegal_o, virtual_o is high in every cycle. The outputs show the verdict for the inputs sampled at the previous rising clock edge. During reset illegal_o is high and the other two outputs are low.
- R2: In machine mode (priv_i = 3'b011) every request is allowed, whatever the enable registers hold.
- R3: For a state request (kind_i = 2'b00) below machine mode, the governed bit is sel_i[7:6] for the register and sel_i[5:0] for the bit. The request is illegal if that bit of mstateen_i is 0. It is also illegal if the bit is undefined. With default parameters the defined bits are bits 0, 1 and 57 to 63 of register 0, and bit 63 of registers 1 to 3.
- R4: In supervisor mode (priv_i = 3'b001) a state request whose machine-level bit is set and defined is allowed.
- R5: In guest supervisor mode (3'b101) or guest user mode (3'b100), a state request that passes the machine-level check but finds the matching hstateen_i bit 0 raises a virtual-instruction exception.
- R6: In user mode (3'b000) or guest user mode, a state request that passes the higher checks but finds the sstateen_i bit 0 is illegal. Supervisor-level bits at positions 32 to 63 count as 0.
- R7: When fp_instr_i is 1 and misa_f_i is 0, the request is checked as a state request on register 0 bit 1, and sel_i is ignored. When fp_instr_i is 1 and misa_f_i is 1, the request is allowed. When misa_f_i is 1, register 0 bit 1 counts as undefined for state requests.
- R8: A request to access a supervisor-level enable register (kind_i = 2'b01) is handled by mode as follows:
  - supervisor mode: allowed if mstateen_i bit 63 of the selected register is set, illegal otherwise;
  - guest supervisor mode: illegal if that machine bit is 0, virtual if the matching hstateen_i bit 63 is 0, allowed otherwise;
  - user mode and guest user mode: illegal.
- R9: A request to access a hypervisor-level enable register (kind_i = 2'b10) is handled by mode as follows:
  - supervisor mode: gated by mstateen_i bit 63 of the selected register, illegal if that bit is 0;
  - guest supervisor mode and guest user mode: virtual;
  - user mode: illegal.
- R10: Request kind 2'b11 is reserved and is illegal below machine mode.
- R11: Mode encodings other than 000, 001, 011, 100 and 101 are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 3 | Current mode: {virtual, level[1:0]} |
| kind_i | input | 2 | 00 state, 01 supervisor enable register, 10 hypervisor enable register, 11 reserved |
| fp_instr_i | input | 1 | Request is a floating-point instruction |
| misa_f_i | input | 1 | Floating-point registers are present |
| sel_i | input | 8 | {register index, bit index} |
| mstateen_i | input | 256 | Machine-level enable bank, register r at bits [64r+63:64r] |
| hstateen_i | input | 256 | Hypervisor-level enable bank |
| sstateen_i | input | 256 | Supervisor-level enable bank in effect for the current mode |
| allow_o | output | 1 | Request may proceed |
| illegal_o | output | 1 | Raise illegal-instruction exception |
| virtual_o | output | 1 | Raise virtual-instruction exception |

## Verification
The bench builds the block with four registers of 64 bits and the default defined-bit mask. With these values the 8-bit selector reaches every register, including the undefined bit 0 of register 1. The bench can also pick bit 57, which is defined at the machine and hypervisor levels but lies in the always-zero upper half of the supervisor bank. The bench builds the bank values so that every bit other than the governed bit holds the opposite value. A wrong index therefore changes the verdict. Floating-point requests are tried with a selector that points away from register 0 bit 1, which shows that the selector is ignored.

// File: rtl/stateen_chk_pkg.sv
package stateen_chk_pkg;

    typedef enum logic [2:0] {
        PRIV_U  = 3'b000,
        PRIV_S  = 3'b001,
        PRIV_M  = 3'b011,
        PRIV_VU = 3'b100,
        PRIV_VS = 3'b101
    } priv_e;

    typedef enum logic [1:0] {
        KIND_STATE = 2'b00,
        KIND_SCSR  = 2'b01,
        KIND_HCSR  = 2'b10,
        KIND_RSVD  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        VERD_ALLOW   = 2'd0,
        VERD_ILLEGAL = 2'd1,
        VERD_VIRTUAL = 2'd2
    } verdict_e;

    typedef struct packed {
        logic allow;
        logic illegal;
        logic virt;
    } result_t;

    // Bit of register 0 that governs floating point without f registers.
    localparam int unsigned FP_GATE_BIT = 1;

    function automatic result_t encode_verdict(input verdict_e v);
        result_t r;
        r.allow   = (v == VERD_ALLOW);
        r.virt    = (v == VERD_VIRTUAL);
        r.illegal = !(r.allow || r.virt);
        return r;
    endfunction

endpackage

// File: rtl/stateen_bit_pick.sv
module stateen_bit_pick #(
    parameter int unsigned NREGS = 4,
    parameter int unsigned XLEN  = 64,
    localparam int unsigned REG_W = $clog2(NREGS),
    localparam int unsigned BIT_W = $clog2(XLEN)
) (
    input  logic [NREGS*XLEN-1:0] bank_i,
    input  logic [REG_W-1:0]      reg_i,
    input  logic [BIT_W-1:0]      bit_i,
    output logic                  bit_o
);
    // Register r occupies bank bits [r*XLEN +: XLEN]; XLEN is a power of two.
    assign bit_o = bank_i[{reg_i, bit_i}];
endmodule

// File: rtl/stateen_index_filter.sv
module stateen_index_filter
    import stateen_chk_pkg::*;
#(
    parameter int unsigned NREGS = 4,
    parameter int unsigned XLEN  = 64,
    parameter logic [NREGS*XLEN-1:0] DEF_MASK = '0,
    localparam int unsigned REG_W = $clog2(NREGS),
    localparam int unsigned BIT_W = $clog2(XLEN)
) (
    input  logic [REG_W-1:0] reg_i,
    input  logic [BIT_W-1:0] bit_i,
    input  logic             misa_f_i,
    output logic             def_ok_o,
    output logic             user_ok_o
);
    logic fp_bit_hit;

    always_comb begin
        fp_bit_hit = (reg_i == '0) && (bit_i == BIT_W'(FP_GATE_BIT));
        def_ok_o   = DEF_MASK[{reg_i, bit_i}] && !(misa_f_i && fp_bit_hit);
        // The supervisor bank only carries the lower half of each register.
        user_ok_o  = def_ok_o && !bit_i[BIT_W-1];
    end
endmodule

// File: rtl/stateen_verdict.sv
module stateen_verdict
    import stateen_chk_pkg::*;
(
    input  logic [2:0] priv_i,
    input  logic [1:0] kind_i,
    input  logic       fp_instr_i,
    input  logic       misa_f_i,
    input  logic       m_bit_i,
    input  logic       h_bit_i,
    input  logic       s_bit_i,
    input  logic       m_gate_i,
    input  logic       h_gate_i,
    input  logic       def_ok_i,
    input  logic       user_ok_i,
    output verdict_e   verdict_o
);
    priv_e p;
    kind_e k;
    logic  is_guest, is_user, valid_priv;
    logic  m_ok, h_ok, s_ok;

    always_comb begin
        p          = priv_e'(priv_i);
        k          = fp_instr_i ? KIND_STATE : kind_e'(kind_i);
        valid_priv = (p == PRIV_U) || (p == PRIV_S) || (p == PRIV_M) ||
                     (p == PRIV_VU) || (p == PRIV_VS);
        is_guest   = (p == PRIV_VS) || (p == PRIV_VU);
        is_user    = (p == PRIV_U) || (p == PRIV_VU);
        m_ok       = m_bit_i && def_ok_i;
        h_ok       = h_bit_i && def_ok_i;
        s_ok       = s_bit_i && user_ok_i;
        verdict_o  = VERD_ILLEGAL;

        if (!valid_priv) begin
            verdict_o = VERD_ILLEGAL;
        end else if (p == PRIV_M) begin
            verdict_o = VERD_ALLOW;
        end else if (fp_instr_i && misa_f_i) begin
            verdict_o = VERD_ALLOW;
        end else begin
            unique case (k)
                KIND_STATE: begin
                    if (!m_ok)                  verdict_o = VERD_ILLEGAL;
                    else if (is_guest && !h_ok) verdict_o = VERD_VIRTUAL;
                    else if (is_user && !s_ok)  verdict_o = VERD_ILLEGAL;
                    else                        verdict_o = VERD_ALLOW;
                end
                KIND_SCSR: begin
                    if (p == PRIV_S)
                        verdict_o = m_gate_i ? VERD_ALLOW : VERD_ILLEGAL;
                    else if (p == PRIV_VS) begin
                        if (!m_gate_i)      verdict_o = VERD_ILLEGAL;
                        else if (!h_gate_i) verdict_o = VERD_VIRTUAL;
                        else                verdict_o = VERD_ALLOW;
                    end else
                        verdict_o = VERD_ILLEGAL;
                end
                KIND_HCSR: begin
                    if (p == PRIV_S)
                        verdict_o = m_gate_i ? VERD_ALLOW : VERD_ILLEGAL;
                    else if (is_guest)
                        verdict_o = VERD_VIRTUAL;
                    else
                        verdict_o = VERD_ILLEGAL;
                end
                default: verdict_o = VERD_ILLEGAL;
            endcase
        end
    end
endmodule

// File: rtl/stateen_access_check.sv
module stateen_access_check
    import stateen_chk_pkg::*;
#(
    parameter int unsigned NREGS = 4,
    parameter int unsigned XLEN  = 64,
    parameter logic [NREGS*XLEN-1:0] DEF_MASK =
        {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
         64'h8000_0000_0000_0000, 64'hFE00_0000_0000_0003},
    localparam int unsigned REG_W = $clog2(NREGS),
    localparam int unsigned BIT_W = $clog2(XLEN),
    localparam int unsigned SEL_W = REG_W + BIT_W,
    localparam int unsigned NPICK = 5
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [2:0]            priv_i,
    input  logic [1:0]            kind_i,
    input  logic                  fp_instr_i,
    input  logic                  misa_f_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic [NREGS*XLEN-1:0] mstateen_i,
    input  logic [NREGS*XLEN-1:0] hstateen_i,
    input  logic [NREGS*XLEN-1:0] sstateen_i,
    output logic                  allow_o,
    output logic                  illegal_o,
    output logic                  virtual_o
);
    typedef struct packed {
        result_t res;
    } state_t;

    state_t   st_d, st_q;
    verdict_e verdict;

    logic [REG_W-1:0] eff_reg;
    logic [BIT_W-1:0] eff_bit;
    logic             def_ok, user_ok;

    // Floating point without f registers is governed by register 0 bit 1.
    assign eff_reg = fp_instr_i ? '0 : sel_i[SEL_W-1 -: REG_W];
    assign eff_bit = fp_instr_i ? BIT_W'(FP_GATE_BIT) : sel_i[BIT_W-1:0];

    // Picks 0..2: governed bit in m/h/s banks; picks 3..4: bit 63 of m/h.
    logic [NPICK-1:0][NREGS*XLEN-1:0] pick_bank;
    logic [NPICK-1:0][BIT_W-1:0]      pick_bit;
    logic [NPICK-1:0]                 picked;

    assign pick_bank = {hstateen_i, mstateen_i, sstateen_i, hstateen_i, mstateen_i};
    assign pick_bit  = {{BIT_W{1'b1}}, {BIT_W{1'b1}}, eff_bit, eff_bit, eff_bit};

    for (genvar g = 0; g < NPICK; g++) begin : g_pick
        stateen_bit_pick #(
            .NREGS (NREGS),
            .XLEN  (XLEN)
        ) u_pick (
            .bank_i (pick_bank[g]),
            .reg_i  (eff_reg),
            .bit_i  (pick_bit[g]),
            .bit_o  (picked[g])
        );
    end

    stateen_index_filter #(
        .NREGS    (NREGS),
        .XLEN     (XLEN),
        .DEF_MASK (DEF_MASK)
    ) u_filter (
        .reg_i     (eff_reg),
        .bit_i     (eff_bit),
        .misa_f_i  (misa_f_i),
        .def_ok_o  (def_ok),
        .user_ok_o (user_ok)
    );

    stateen_verdict u_verdict (
        .priv_i     (priv_i),
        .kind_i     (kind_i),
        .fp_instr_i (fp_instr_i),
        .misa_f_i   (misa_f_i),
        .m_bit_i    (picked[0]),
        .h_bit_i    (picked[1]),
        .s_bit_i    (picked[2]),
        .m_gate_i   (picked[3]),
        .h_gate_i   (picked[4]),
        .def_ok_i   (def_ok),
        .user_ok_i  (user_ok),
        .verdict_o  (verdict)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = encode_verdict(verdict);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.res <= '{allow: 1'b0, illegal: 1'b1, virt: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign allow_o   = st_q.res.allow;
    assign illegal_o = st_q.res.illegal;
    assign virtual_o = st_q.res.virt;

    // R1: one verdict per cycle
    a_r1_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot({allow_o, illegal_o, virtual_o}));

    // R2: machine mode never denied
    a_r2_machine_allow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (priv_i == PRIV_M) |=> allow_o);

    // R3: a clear machine-level bit denies as illegal below machine mode
    a_r3_machine_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (priv_i != PRIV_M && kind_i == KIND_STATE && !fp_instr_i && !mstateen_i[sel_i])
        |=> illegal_o);

    // R5: a clear hypervisor-level bit never lets a guest through
    a_r5_guest_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((priv_i == PRIV_VS || priv_i == PRIV_VU) && kind_i == KIND_STATE &&
         !fp_instr_i && !hstateen_i[sel_i]) |=> !allow_o);

    // R8: supervisor enable register access needs machine bit 63
    a_r8_csr_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i == KIND_SCSR && !fp_instr_i && (priv_i == PRIV_S || priv_i == PRIV_VS) &&
         !mstateen_i[{sel_i[SEL_W-1 -: REG_W], {BIT_W{1'b1}}}]) |=> illegal_o);

    // R11: unknown mode encodings are illegal
    a_r11_bad_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (priv_i == 3'b010 || priv_i == 3'b110 || priv_i == 3'b111) |=> illegal_o);

endmodule

// File: tb/stateen_access_check_bench.sv
module stateen_access_check_bench;

    localparam logic [2:0] PU = 3'b000, PS = 3'b001, PM = 3'b011, PVU = 3'b100, PVS = 3'b101;
    localparam logic [1:0] EA = 2'd0, EI = 2'd1, EV = 2'd2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [2:0]   priv;
    logic [1:0]   kind;
    logic         fp, mf;
    logic [7:0]   sel;
    logic [255:0] mv, hv, sv;
    logic         allow, illegal, virt;

    always #4 clk = ~clk;

    stateen_access_check u_stateen_access_check (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .priv_i     (priv),
        .kind_i     (kind),
        .fp_instr_i (fp),
        .misa_f_i   (mf),
        .sel_i      (sel),
        .mstateen_i (mv),
        .hstateen_i (hv),
        .sstateen_i (sv),
        .allow_o    (allow),
        .illegal_o  (illegal),
        .virtual_o  (virt)
    );

    typedef struct packed {
        logic [2:0] priv;
        logic [1:0] kind;
        logic       fp;
        logic       mf;
        logic [7:0] sel;
        logic       mb, hb, sb, m63, h63;
        logic [1:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        '{PM,  2'd0, 1'b0, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0, EA, 4'd2},  // R2
        '{PS,  2'd0, 1'b0, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b1,1'b1, EA, 4'd4},  // R4
        '{PS,  2'd0, 1'b0, 1'b0, 8'h00, 1'b0,1'b1,1'b1,1'b1,1'b1, EI, 4'd3},  // R3
        '{PU,  2'd0, 1'b0, 1'b0, 8'h00, 1'b1,1'b1,1'b1,1'b1,1'b1, EA, 4'd6},  // R6
        '{PU,  2'd0, 1'b0, 1'b0, 8'h00, 1'b1,1'b1,1'b0,1'b1,1'b1, EI, 4'd6},  // R6
        '{PVS, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1,1'b0,1'b1,1'b1,1'b1, EV, 4'd5},  // R5
        '{PVS, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0,1'b1,1'b1,1'b1,1'b1, EI, 4'd3},  // R3
        '{PVU, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1,1'b1,1'b1,1'b1,1'b1, EA, 4'd6},  // R6
        '{PVU, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1,1'b1,1'b0,1'b1,1'b1, EI, 4'd6},  // R6
        '{PVU, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b1,1'b1, EV, 4'd5},  // R5
        '{PS,  2'd0, 1'b0, 1'b0, 8'h39, 1'b1,1'b0,1'b0,1'b0,1'b0, EA, 4'd4},  // R4 bit 57
        '{PU,  2'd0, 1'b0, 1'b0, 8'h39, 1'b1,1'b1,1'b1,1'b1,1'b1, EI, 4'd6},  // R6 upper half
        '{PS,  2'd0, 1'b0, 1'b0, 8'h05, 1'b1,1'b1,1'b1,1'b1,1'b1, EI, 4'd3},  // R3 undefined
        '{PS,  2'd0, 1'b0, 1'b0, 8'h40, 1'b1,1'b1,1'b1,1'b1,1'b1, EI, 4'd3},  // R3 reg 1 bit 0
        '{PVS, 2'd0, 1'b0, 1'b0, 8'h39, 1'b1,1'b1,1'b0,1'b1,1'b1, EA, 4'd5},  // R5
        '{PS,  2'd1, 1'b0, 1'b0, 8'h80, 1'b0,1'b0,1'b0,1'b1,1'b0, EA, 4'd8},  // R8
        '{PS,  2'd1, 1'b0, 1'b0, 8'h80, 1'b1,1'b1,1'b1,1'b0,1'b1, EI, 4'd8},  // R8
        '{PVS, 2'd1, 1'b0, 1'b0, 8'h40, 1'b1,1'b1,1'b1,1'b1,1'b0, EV, 4'd8},  // R8
        '{PVS, 2'd1, 1'b0, 1'b0, 8'h40, 1'b1,1'b1,1'b1,1'b0,1'b1, EI, 4'd8},  // R8
        '{PVS, 2'd1, 1'b0, 1'b0, 8'h40, 1'b0,1'b0,1'b0,1'b1,1'b1, EA, 4'd8},  // R8
        '{PU,  2'd1, 1'b0, 1'b0, 8'h00, 1'b1,1'b1,1'b1,1'b1,1'b1, EI, 4'd8},  // R8
        '{PS,  2'd2, 1'b0, 1'b0, 8'hC0, 1'b0,1'b0,1'b0,1'b1,1'b0, EA, 4'd9},  // R9
        '{PS,  2'd2, 1'b0, 1'b0, 8'hC0, 1'b1,1'b1,1'b1,1'b0,1'b1, EI, 4'd9},  // R9
        '{PVS, 2'd2, 1'b0, 1'b0, 8'h00, 1'b1,1'b1,1'b1,1'b1,1'b1, EV, 4'd9},  // R9
        '{PM,  2'd2, 1'b0, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0, EA, 4'd2},  // R2
        '{PU,  2'd0, 1'b1, 1'b0, 8'h01, 1'b1,1'b1,1'b1,1'b1,1'b1, EA, 4'd7},  // R7
        '{PU,  2'd0, 1'b1, 1'b0, 8'h01, 1'b1,1'b1,1'b0,1'b1,1'b1, EI, 4'd7},  // R7
        '{PVS, 2'd0, 1'b1, 1'b0, 8'h01, 1'b1,1'b0,1'b1,1'b1,1'b1, EV, 4'd7},  // R7
        '{PU,  2'd0, 1'b1, 1'b1, 8'h01, 1'b0,1'b0,1'b0,1'b0,1'b0, EA, 4'd7},  // R7
        '{PS,  2'd0, 1'b0, 1'b1, 8'h01, 1'b1,1'b1,1'b1,1'b1,1'b1, EI, 4'd7},  // R7
        '{3'b010, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1,1'b1,1'b1,1'b1,1'b1, EI, 4'd11}, // R11
        '{3'b111, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1,1'b1,1'b1,1'b1,1'b1, EI, 4'd11}, // R11
        '{PS,  2'd3, 1'b0, 1'b0, 8'h00, 1'b1,1'b1,1'b1,1'b1,1'b1, EI, 4'd10}, // R10
        '{PM,  2'd3, 1'b0, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0, EA, 4'd2},  // R2
        '{PU,  2'd2, 1'b0, 1'b0, 8'h00, 1'b1,1'b1,1'b1,1'b1,1'b1, EI, 4'd9},  // R9
        '{PVU, 2'd1, 1'b0, 1'b0, 8'h00, 1'b1,1'b1,1'b1,1'b1,1'b1, EI, 4'd8}   // R8
    };

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // Every bit other than the governed one takes the opposite value.
    function automatic logic [255:0] build(input logic [7:0] s, input logic b, input logic g);
        logic [255:0] v;
        v = {256{~b}};
        v[s] = b;
        v[{s[7:6], 6'd63}] = g;
        return v;
    endfunction

    task automatic expect_code(input logic [1:0] code, input int req, input string what);
        logic [2:0] want;
        case (code)
            EA:      want = 3'b100;
            EV:      want = 3'b001;
            default: want = 3'b010;
        endcase
        n_checks++;
        if ({allow, illegal, virt} !== want) begin
            n_fails++;
            $display("FAIL R%0d %s: allow/illegal/virtual got %b expected %b",
                     req, what, {allow, illegal, virt}, want);
        end
    endtask

    task automatic drive_and_check(input logic [2:0] p, input logic [1:0] k, input logic f,
                                   input logic m, input logic [7:0] s,
                                   input logic [255:0] a, input logic [255:0] b,
                                   input logic [255:0] c, input logic [1:0] code,
                                   input int req, input string what);
        @(negedge clk);
        priv = p; kind = k; fp = f; mf = m; sel = s; mv = a; hv = b; sv = c;
        @(negedge clk);
        expect_code(code, req, what);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        priv = PM; kind = 2'd0; fp = 1'b0; mf = 1'b0; sel = '0;
        mv = '1; hv = '1; sv = '1;
        repeat (3) @(negedge clk);
        expect_code(EI, 1, "reset value");  // R1 reset verdict
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive_and_check(VEC[i].priv, VEC[i].kind, VEC[i].fp, VEC[i].mf, VEC[i].sel,
                            build(VEC[i].sel, VEC[i].mb, VEC[i].m63),
                            build(VEC[i].sel, VEC[i].hb, VEC[i].h63),
                            build(VEC[i].sel, VEC[i].sb, ~VEC[i].sb),
                            VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
        end

        // R7: the selector is ignored for floating point; only reg 0 bit 1 counts
        drive_and_check(PU, 2'd0, 1'b1, 1'b0, 8'h00, 256'h2, 256'h2, 256'h2,
                        EA, 7, "fp selector ignored, bit1 set");
        drive_and_check(PU, 2'd0, 1'b1, 1'b0, 8'h00, 256'h1, 256'h1, 256'h1,
                        EI, 7, "fp selector ignored, bit1 clear");
        // R1: back-to-back verdict changes track the previous edge
        drive_and_check(PVS, 2'd0, 1'b0, 1'b0, 8'h00, '1, '0, '1, EV, 1, "latency virtual");
        drive_and_check(PM,  2'd0, 1'b0, 1'b0, 8'h00, '0, '0, '0, EA, 1, "latency allow");
        // R1: reset mid-run returns the illegal verdict
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        expect_code(EI, 1, "reset in flight");
        rst_n = 1'b1;
        drive_and_check(PS, 2'd0, 1'b0, 1'b0, 8'h39, '1, '0, '0, EA, 4, "after reset");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule